// File: doc/BRIEF.md
# USB Interrupt Flag Aggregation Unit

This block gathers event strobes from a USB function controller into three sticky flag groups. The first group holds bus-wide events: suspend, resume, bus reset and start-of-frame. The second holds endpoint 0 together with every IN endpoint. The third holds the OUT endpoints 1 to 5. Each group has an enable mask of the same width. A CPU reads and writes the six registers over a simple strobe bus. Reading a flag register returns its contents and empties it in the same access, so software has to keep the returned word.

From the flags and masks the block forms a level pending signal for the USB source. It then merges that signal with a general-purpose port interrupt into one shared CPU request line. A module enable input acts as the controller reset. While it is low, every flag and mask is held at its reset value and incoming events are dropped.

Top module: `usbirq_hub`

## Requirements
- R1: Register map on `addr`. 0 is the common flags, 1 the IN flags, 2 the OUT flags, 4 the common mask, 5 the IN mask and 6 the OUT mask. Addresses 3 and 7 read as 0. `rdata` reflects the addressed register in the same cycle.
- R2: An event strobe sets its flag at the next clock edge whether or not its enable bit is set. Common bits are: bit 0 suspend, bit 1 resume, bit 2 bus reset, bit 3 start-of-frame. IN bit n is endpoint n (0 to 5). `evt_out[k]` is OUT endpoint k+1 and lands on OUT bit k+1.
- R3: A read (`rd_en` high) of a flag register returns its current value, and all of its bits are clear from the next cycle on.
- R4: An event that arrives in the same cycle as a read of its flag register is still set after the read-clear.
- R5: After reset the common mask is 0x06 (suspend and start-of-frame disabled), the IN mask is 0x3F and the OUT mask is 0x3E.
- R6: Writes (`wr_en` high) to flag registers change nothing. Writes to mask registers store `wdata` masked to the group's implemented bits.
- R7: Unimplemented bits read 0. These are common bits 7:4, IN bits 7:6, and OUT bits 7:6 and bit 0.
- R8: `usb_pend` is high exactly while some flag is set whose matching mask bit is also set.
- R9: `irq_req` is high when (`usb_pend` and `cpu_usb_ie`) or (`port_pend` and `port_ie`) holds, and low otherwise.
- R10: While `mod_en` is low the flags are 0, the masks hold their R5 values, events are ignored and `usb_pend` is low. Raising `mod_en` releases the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; low holds the block in reset |
| rd_en | input | 1 | Register read strobe (clears a flag register) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| evt_common | input | 4 | Suspend, resume, bus reset, start-of-frame strobes |
| evt_in | input | 6 | Endpoint 0 and IN endpoint 1..5 strobes |
| evt_out | input | 5 | OUT endpoint 1..5 strobes |
| cpu_usb_ie | input | 1 | CPU-level USB interrupt enable |
| port_pend | input | 1 | Pending flag of the shared port interrupt |
| port_ie | input | 1 | Enable of the shared port interrupt |
| usb_pend | output | 1 | Level USB pending status |
| irq_req | output | 1 | Shared interrupt request to the CPU |

## Verification
The assertions assume that strobes are single-cycle levels sampled at the rising edge. They also assume that `rd_en` and `wr_en` are not raised together on a flag address. A few properties hold only when no event hits the addressed group in that cycle, so their antecedents check that. The stimulus drives every input one time unit after the rising edge and returns each strobe to zero after one cycle. It never pairs a read and a write, and it raises a coincident event only in the dedicated R4 step.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int DW         = 8;
    localparam int AW         = 3;
    localparam int NGRP       = 3;
    localparam int NUM_EP     = 6;
    localparam int NCOMMON    = 4;
    localparam int NOUT       = NUM_EP - 1;

    localparam int BIT_SUSPEND = 0;
    localparam int BIT_RESUME  = 1;
    localparam int BIT_BUSRST  = 2;
    localparam int BIT_SOF     = 3;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        GRP_COMMON = 2'd0,
        GRP_IN     = 2'd1,
        GRP_OUT    = 2'd2,
        GRP_NONE   = 2'd3
    } grp_e;

    typedef struct packed {
        logic       is_mask;
        logic [1:0] grp;
    } reg_addr_t;

    function automatic word_t grp_valid(input int g);
        word_t v;
        v = '0;
        case (g)
            0: for (int b = 0; b < NCOMMON; b++) v[b] = 1'b1;
            1: for (int b = 0; b < NUM_EP; b++) v[b] = 1'b1;
            2: for (int b = 1; b < NUM_EP; b++) v[b] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic word_t grp_en_init(input int g);
        word_t v;
        v = grp_valid(g);
        if (g == 0) begin
            v[BIT_SUSPEND] = 1'b0;
            v[BIT_SOF]     = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/usbirq_group.sv
module usbirq_group
    import usbirq_pkg::*;
#(
    parameter int    W       = DW,
    parameter word_t VALID   = '1,
    parameter word_t EN_INIT = '1
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] flags,
    output logic [W-1:0] enables,
    output logic         hit
);

    localparam logic [W-1:0] VMASK  = VALID[W-1:0];
    localparam logic [W-1:0] EN_RST = EN_INIT[W-1:0] & VMASK;

    logic [W-1:0] flag_keep;
    logic [W-1:0] flag_nxt;

    always_comb begin
        flag_keep = rd_clr ? '0 : flags;
        flag_nxt  = (flag_keep | evt) & VMASK;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            flags <= '0;
        end else begin
            flags <= flag_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            enables <= EN_RST;
        end else if (en_we) begin
            enables <= en_wdata & VMASK;
        end
    end

    assign hit = |(flags & enables);

endmodule

// File: rtl/usbirq_regbus.sv
module usbirq_regbus
    import usbirq_pkg::*;
(
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  word_t           flg [NGRP],
    input  word_t           msk [NGRP],
    output logic [NGRP-1:0] rd_clr,
    output logic [NGRP-1:0] en_we,
    output word_t           rdata
);

    reg_addr_t ra;
    logic      mapped;

    assign ra     = reg_addr_t'(addr);
    assign mapped = (ra.grp != GRP_NONE);

    always_comb begin
        rd_clr = '0;
        en_we  = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (ra.grp == 2'(g)) begin
                rd_clr[g] = rd_en & ~ra.is_mask;
                en_we[g]  = wr_en &  ra.is_mask;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (mapped && ra.grp == 2'(g)) begin
                rdata = ra.is_mask ? msk[g] : flg[g];
            end
        end
    end

endmodule

// File: rtl/usbirq_combine.sv
module usbirq_combine
    import usbirq_pkg::*;
(
    input  logic [NGRP-1:0] hit,
    input  logic            cpu_usb_ie,
    input  logic            port_pend,
    input  logic            port_ie,
    output logic            usb_pend,
    output logic            irq_req
);

    logic usb_req;
    logic port_req;

    assign usb_pend = |hit;
    assign usb_req  = usb_pend & cpu_usb_ie;
    assign port_req = port_pend & port_ie;
    assign irq_req  = usb_req | port_req;

endmodule

// File: rtl/usbirq_hub.sv
module usbirq_hub
    import usbirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mod_en,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NCOMMON-1:0] evt_common,
    input  logic [NUM_EP-1:0]  evt_in,
    input  logic [NOUT-1:0]    evt_out,
    input  logic               cpu_usb_ie,
    input  logic               port_pend,
    input  logic               port_ie,
    output logic               usb_pend,
    output logic               irq_req
);

    logic            srst_eff;
    word_t           evt_v [NGRP];
    word_t           flg_q [NGRP];
    word_t           msk_q [NGRP];
    logic [NGRP-1:0] hit;
    logic [NGRP-1:0] rd_clr;
    logic [NGRP-1:0] en_we;

    assign srst_eff = rst | ~mod_en;

    always_comb begin
        evt_v[GRP_COMMON] = '0;
        evt_v[GRP_IN]     = '0;
        evt_v[GRP_OUT]    = '0;
        evt_v[GRP_COMMON][NCOMMON-1:0] = evt_common;
        evt_v[GRP_IN][NUM_EP-1:0]      = evt_in;
        evt_v[GRP_OUT][NUM_EP-1:1]     = evt_out;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        usbirq_group #(
            .W       (DW),
            .VALID   (grp_valid(g)),
            .EN_INIT (grp_en_init(g))
        ) u_grp (
            .clk      (clk),
            .srst     (srst_eff),
            .evt      (evt_v[g]),
            .rd_clr   (rd_clr[g]),
            .en_we    (en_we[g]),
            .en_wdata (wdata),
            .flags    (flg_q[g]),
            .enables  (msk_q[g]),
            .hit      (hit[g])
        );
    end

    usbirq_regbus u_bus (
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .flg    (flg_q),
        .msk    (msk_q),
        .rd_clr (rd_clr),
        .en_we  (en_we),
        .rdata  (rdata)
    );

    usbirq_combine u_comb (
        .hit        (hit),
        .cpu_usb_ie (cpu_usb_ie),
        .port_pend  (port_pend),
        .port_ie    (port_ie),
        .usb_pend   (usb_pend),
        .irq_req    (irq_req)
    );

endmodule

// File: rtl/usbirq_hub_chk.sv
module usbirq_hub_chk
    import usbirq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mod_en,
    input logic               rd_en,
    input logic               wr_en,
    input logic [AW-1:0]      addr,
    input logic [DW-1:0]      wdata,
    input logic [DW-1:0]      rdata,
    input logic [NCOMMON-1:0] evt_common,
    input logic [NUM_EP-1:0]  evt_in,
    input logic               cpu_usb_ie,
    input logic               port_pend,
    input logic               port_ie,
    input logic               usb_pend,
    input logic               irq_req,
    input word_t              flg_c,
    input word_t              flg_i,
    input word_t              flg_o,
    input word_t              en_c
);

    // R2
    common_set_chk: assert property (@(posedge clk) disable iff (rst || !mod_en)
        (|evt_common) |=> ((flg_c[NCOMMON-1:0] & $past(evt_common)) == $past(evt_common)));

    // R4
    in_set_chk: assert property (@(posedge clk) disable iff (rst || !mod_en)
        (|evt_in) |=> ((flg_i[NUM_EP-1:0] & $past(evt_in)) == $past(evt_in)));

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst || !mod_en)
        (rd_en && addr == 3'd1 && evt_in == '0) |=> (flg_i == '0));

    // R6
    flag_wr_ign_chk: assert property (@(posedge clk) disable iff (rst || !mod_en)
        (wr_en && !rd_en && addr == 3'd0 && evt_common == '0) |=> (flg_c == $past(flg_c)));

    // R6
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst || !mod_en)
        (wr_en && addr == 3'd4) |=> (en_c == ($past(wdata) & 8'h0F)));

    // R1
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] == 2'b11) |-> (rdata == '0));

    // R7
    spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (flg_c[7:4] == 4'd0) && (flg_i[7:6] == 2'd0) && (flg_o[7:6] == 2'd0) && !flg_o[0]);

    // R8
    no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (flg_c == '0 && flg_i == '0 && flg_o == '0) |-> !usb_pend);

    // R9
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!(usb_pend && cpu_usb_ie) && !(port_pend && port_ie)) |-> !irq_req);

    // R9
    port_share_chk: assert property (@(posedge clk) disable iff (rst)
        (port_pend && port_ie) |-> irq_req);

    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mod_en) |=> (flg_c == '0 && flg_i == '0 && flg_o == '0 && !usb_pend));

endmodule

bind usbirq_hub usbirq_hub_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mod_en     (mod_en),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .evt_common (evt_common),
    .evt_in     (evt_in),
    .cpu_usb_ie (cpu_usb_ie),
    .port_pend  (port_pend),
    .port_ie    (port_ie),
    .usb_pend   (usb_pend),
    .irq_req    (irq_req),
    .flg_c      (flg_q[0]),
    .flg_i      (flg_q[1]),
    .flg_o      (flg_q[2]),
    .en_c       (msk_q[0])
);

// File: tb/usbirq_hub_bench.sv
module usbirq_hub_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_en = 1'b1;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] evt_common = '0;
    logic [5:0] evt_in = '0;
    logic [4:0] evt_out = '0;
    logic       cpu_usb_ie = 1'b0;
    logic       port_pend = 1'b0;
    logic       port_ie = 1'b0;
    logic       usb_pend;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] a;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q [$];

    always #2 clk = ~clk;

    usbirq_hub u_usbirq_hub (
        .clk        (clk),
        .rst        (rst),
        .mod_en     (mod_en),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .evt_common (evt_common),
        .evt_in     (evt_in),
        .evt_out    (evt_out),
        .cpu_usb_ie (cpu_usb_ie),
        .port_pend  (port_pend),
        .port_ie    (port_ie),
        .usb_pend   (usb_pend),
        .irq_req    (irq_req)
    );

    // monitor: compares read data with the queued expectation
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read addr=%0d actual=%02h expected=none", addr, rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                if (rdata !== it.exp || addr !== it.a) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, addr, rdata, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        wr_en = 1'b0;
        evt_common = '0;
        evt_in = '0;
        evt_out = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.a = a;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        addr = a;
        rd_en = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        tick();
    endtask

    task automatic evt(input logic [3:0] c, input logic [5:0] i, input logic [4:0] o);
        evt_common = c;
        evt_in = i;
        evt_out = o;
        tick();
    endtask

    task automatic lvl(input logic exp_pend, input logic exp_req, input string tag);
        @(negedge clk);
        checks++;
        if (usb_pend !== exp_pend || irq_req !== exp_req) begin
            errors++;
            $display("FAIL %s pend/req actual=%b%b expected=%b%b", tag, usb_pend, irq_req, exp_pend, exp_req);
        end
        tick();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        tick();

        // R5, R1: reset values and map
        rd(3'd4, 8'h06, "R5 common mask");
        rd(3'd5, 8'h3F, "R5 in mask");
        rd(3'd6, 8'h3E, "R5 out mask");
        rd(3'd0, 8'h00, "R1 common flags");
        rd(3'd1, 8'h00, "R1 in flags");
        rd(3'd2, 8'h00, "R1 out flags");
        rd(3'd3, 8'h00, "R1 addr3");
        rd(3'd7, 8'h00, "R1 addr7");
        lvl(1'b0, 1'b0, "R8 idle");

        // R2: suspend flag set although its enable is off
        evt(4'b0001, '0, '0);
        lvl(1'b0, 1'b0, "R8 disabled suspend");
        rd(3'd0, 8'h01, "R2 suspend flag");
        rd(3'd0, 8'h00, "R3 cleared");

        // R8, R9: IN endpoint 2
        evt('0, 6'b000100, '0);
        lvl(1'b1, 1'b0, "R9 cpu ie off");
        cpu_usb_ie = 1'b1;
        lvl(1'b1, 1'b1, "R9 cpu ie on");
        rd(3'd1, 8'h04, "R2 in ep2");
        lvl(1'b0, 1'b0, "R3 pend after clear");

        // R4: coincident event during read
        evt('0, '0, 5'b00001);
        evt_out = 5'b01000;
        rd(3'd2, 8'h02, "R2 out ep1");
        rd(3'd2, 8'h10, "R4 ep4 kept");
        rd(3'd2, 8'h00, "R3 out cleared");

        // R6: flag writes ignored
        evt(4'b0010, '0, '0);
        wr(3'd0, 8'h00);
        rd(3'd0, 8'h02, "R6 flag write zero");
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'hFF);
        rd(3'd0, 8'h00, "R6 flag write ones");
        rd(3'd2, 8'h00, "R6 out flag write");

        // R6, R7: mask writes
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h0F, "R7 common mask bits");
        wr(3'd6, 8'hFF);
        rd(3'd6, 8'h3E, "R7 out mask bits");
        wr(3'd5, 8'hA5);
        rd(3'd5, 8'h25, "R6 in mask write");

        // R8: start-of-frame now enabled
        evt(4'b1000, '0, '0);
        lvl(1'b1, 1'b1, "R8 sof enabled");
        rd(3'd0, 8'h08, "R2 sof flag");

        wr(3'd5, 8'h00);
        evt('0, 6'b000001, '0);
        lvl(1'b0, 1'b0, "R8 masked ep0");
        rd(3'd1, 8'h01, "R2 ep0 flag");

        // R9: shared port source
        cpu_usb_ie = 1'b0;
        port_pend = 1'b1;
        lvl(1'b0, 1'b0, "R9 port ie off");
        port_ie = 1'b1;
        lvl(1'b0, 1'b1, "R9 port request");
        port_pend = 1'b0;
        lvl(1'b0, 1'b0, "R9 port idle");

        // R10: module enable low
        cpu_usb_ie = 1'b1;
        evt(4'b0100, 6'b100000, '0);
        mod_en = 1'b0;
        tick();
        evt(4'b0001, 6'b000010, 5'b10000);
        lvl(1'b0, 1'b0, "R10 pend off");
        rd(3'd0, 8'h00, "R10 common held");
        rd(3'd1, 8'h00, "R10 in held");
        rd(3'd5, 8'h3F, "R10 in mask reset");
        mod_en = 1'b1;
        tick();
        rd(3'd4, 8'h06, "R10 common mask reset");
        rd(3'd2, 8'h00, "R10 out clear");
        lvl(1'b0, 1'b0, "R10 after release");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule